// File: doc/BRIEF.md
# Dual-Bank 7:1 Video Serializer

This block turns wide parallel pixel words into bit-serial lanes for a flat-panel link. It runs entirely on a bit-rate clock at seven times the pixel rate. The slower pixel clock comes in as a plain input and is sampled on that bit clock. On the selected edge of the pixel clock, one parallel word per bank is captured into a holding register. One bit clock later the word is loaded into per-lane shift registers. Each lane then sends its seven bits, one per bit clock, in a fixed non-sequential order.

There are two banks, odd and even. Each bank has a number of data lanes (five by default) and one clock lane that repeats a fixed seven-bit shape every pixel period. In single-pixel mode only the odd bank carries traffic. In dual-pixel mode both banks do. Each bank can also be turned off by its own enable. Each lane can be silenced by its own disable bit. An active-low power-down input stops capture and clears the datapath. Every inactive output drives a steady 0.

Top module: `vsr_serializer`

## Requirements
- R1: Within one pixel period, each data lane sends seven bits on consecutive bit clocks. The order is parallel bit 1, 0, 6, 5, 4, 3, 2, where data lane L of a bank takes its parallel bits from positions 7*L to 7*L+6 of that bank's pixel input.
- R2: The capture edge is the first rising bit-clock edge at which the sampled pixel clock shows the selected transition. The first serial bit of the captured word is on the outputs after the next rising bit-clock edge.
- R3: `edge_sel` = 1 captures on a 0-to-1 transition of `pix_clk`, and `edge_sel` = 0 on a 1-to-0 transition. The other transition captures nothing.
- R4: Each active clock lane sends 1,1,0,0,0,1,1 (first to last) in the same seven bit slots as its bank's data.
- R5: With `dual_mode` = 0 (single-pixel), every even-bank output is 0 and the odd bank operates normally.
- R6: With `dual_mode` = 1 (dual-pixel), both banks serialize their own words at the same time.
- R7: A bank whose enable input is 0 drives 0 on all of its data lanes and on its clock lane.
- R8: Bit L of a bank's lane-disable input set to 1 forces data lane L of that bank to 0. Lanes whose bit is 0 are unaffected.
- R9: While `pwr_n` is 0, no word is captured and every output is 0.
- R10: During reset all outputs are 0.
- R11: Changes on the pixel inputs between two capture edges do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on `clk` |
| edge_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| dual_mode | input | 1 | 1 dual-pixel, 0 single-pixel (odd bank only) |
| odd_en | input | 1 | Odd bank enable |
| even_en | input | 1 | Even bank enable |
| pwr_n | input | 1 | Active-low power-down |
| odd_lane_dis | input | LANES | Per-lane disable, odd bank |
| even_lane_dis | input | LANES | Per-lane disable, even bank |
| odd_pix | input | 7*LANES | Parallel word, odd bank |
| even_pix | input | 7*LANES | Parallel word, even bank |
| odd_ser | output | LANES | Serial data lanes, odd bank |
| even_ser | output | LANES | Serial data lanes, even bank |
| odd_clk_ser | output | 1 | Clock lane, odd bank |
| even_clk_ser | output | 1 | Clock lane, even bank |

## Verification
The bench builds the block with the default of five lanes per bank. This puts every lane-disable bit position and the full 35-bit word per bank within reach. With twelve output lanes compared per frame, a slip in the bit order or a wrong lane index shows up on a single random word. The bench issues back-to-back frames every seven bit clocks. It changes the pixel inputs at the non-selected transition, in both edge polarities, which exposes capture on the wrong edge and frames torn across periods.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  // bit slots per pixel period
  localparam int UI_PER_PIX = 7;
  // clock lane shape, bit [UI_PER_PIX-1] leaves first
  localparam logic [UI_PER_PIX-1:0] CLK_SHAPE = 7'b1100011;

  // parallel bit index sent in serial slot pos (slot 0 first): 1,0,6,5,4,3,2
  function automatic int src_bit(input int pos);
    return (pos < 2) ? (1 - pos) : (UI_PER_PIX + 1 - pos);
  endfunction
endpackage

// File: rtl/vsr_strobe.sv
module vsr_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_clk,
  input  logic edge_sel,
  input  logic pwr_n,
  output logic cap,
  output logic load
);
  logic pix_q, pix_d;
  logic armed_q, armed_d;
  logic load_q, load_d;
  logic edge_seen;

  always_comb begin
    edge_seen = (pix_clk != pix_q) && (pix_clk == edge_sel);
    cap       = armed_q && pwr_n && edge_seen;
    pix_d     = pix_clk;
    armed_d   = 1'b1;
    load_d    = cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= 1'b0;
      armed_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      pix_q   <= pix_d;
      armed_q <= armed_d;
      load_q  <= load_d;
    end
  end

  assign load = load_q;
endmodule

// File: rtl/vsr_bank.sv
module vsr_bank #(
  parameter int LANES = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clr,
  input  logic                                  cap,
  input  logic                                  load,
  input  logic                                  active,
  input  logic [LANES-1:0]                      lane_dis,
  input  logic [LANES*vsr_pkg::UI_PER_PIX-1:0]  pix,
  output logic [LANES-1:0]                      ser,
  output logic                                  clk_ser
);
  import vsr_pkg::*;
  localparam int W = LANES * UI_PER_PIX;

  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    if (clr)      hold_d = '0;
    else if (cap) hold_d = pix;
    else          hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [UI_PER_PIX-1:0] sh_q, sh_d, ld_word;

    always_comb begin
      for (int p = 0; p < UI_PER_PIX; p++)
        ld_word[UI_PER_PIX-1-p] = hold_q[l*UI_PER_PIX + src_bit(p)];
      if (clr)       sh_d = '0;
      else if (load) sh_d = ld_word;
      else           sh_d = {sh_q[UI_PER_PIX-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign ser[l] = sh_q[UI_PER_PIX-1] & active & ~lane_dis[l];
  end

  logic [UI_PER_PIX-1:0] ck_q, ck_d;

  always_comb begin
    if (clr)       ck_d = '0;
    else if (load) ck_d = CLK_SHAPE;
    else           ck_d = {ck_q[UI_PER_PIX-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= '0;
    else        ck_q <= ck_d;
  end

  assign clk_ser = ck_q[UI_PER_PIX-1] & active;
endmodule

// File: rtl/vsr_serializer.sv
module vsr_serializer #(
  parameter int LANES = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pix_clk,
  input  logic                                  edge_sel,
  input  logic                                  dual_mode,
  input  logic                                  odd_en,
  input  logic                                  even_en,
  input  logic                                  pwr_n,
  input  logic [LANES-1:0]                      odd_lane_dis,
  input  logic [LANES-1:0]                      even_lane_dis,
  input  logic [LANES*vsr_pkg::UI_PER_PIX-1:0]  odd_pix,
  input  logic [LANES*vsr_pkg::UI_PER_PIX-1:0]  even_pix,
  output logic [LANES-1:0]                      odd_ser,
  output logic [LANES-1:0]                      even_ser,
  output logic                                  odd_clk_ser,
  output logic                                  even_clk_ser
);
  logic cap, load;
  logic odd_active, even_active, clr;

  always_comb begin
    clr         = ~pwr_n;
    odd_active  = pwr_n & odd_en;
    even_active = pwr_n & even_en & dual_mode;
  end

  vsr_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_clk  (pix_clk),
    .edge_sel (edge_sel),
    .pwr_n    (pwr_n),
    .cap      (cap),
    .load     (load)
  );

  vsr_bank #(.LANES(LANES)) u_odd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cap      (cap),
    .load     (load),
    .active   (odd_active),
    .lane_dis (odd_lane_dis),
    .pix      (odd_pix),
    .ser      (odd_ser),
    .clk_ser  (odd_clk_ser)
  );

  vsr_bank #(.LANES(LANES)) u_even (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cap      (cap),
    .load     (load),
    .active   (even_active),
    .lane_dis (even_lane_dis),
    .pix      (even_pix),
    .ser      (even_ser),
    .clk_ser  (even_clk_ser)
  );
endmodule

// File: rtl/vsr_checker.sv
module vsr_checker #(
  parameter int LANES = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_clk,
  input logic             edge_sel,
  input logic             dual_mode,
  input logic             odd_en,
  input logic             pwr_n,
  input logic [LANES-1:0] odd_lane_dis,
  input logic [LANES-1:0] even_lane_dis,
  input logic [LANES-1:0] odd_ser,
  input logic [LANES-1:0] even_ser,
  input logic             odd_clk_ser,
  input logic             even_clk_ser,
  input logic             cap,
  input logic             load
);
  assert_capture_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (pix_clk == edge_sel) && (pix_clk != $past(pix_clk)));

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && pwr_n) |=> (odd_clk_ser == (pwr_n && odd_en)));

  assert_pwrdn_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> !load);

  assert_single_even_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> (even_ser == '0) && !even_clk_ser);

  assert_odd_bank_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_en |-> (odd_ser == '0) && !odd_clk_ser);

  for (genvar i = 0; i < LANES; i++) begin : g_dis
    assert_odd_lane_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      odd_lane_dis[i] |-> !odd_ser[i]);
    assert_even_lane_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      even_lane_dis[i] |-> !even_ser[i]);
  end
endmodule

bind vsr_serializer vsr_checker #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pix_clk       (pix_clk),
  .edge_sel      (edge_sel),
  .dual_mode     (dual_mode),
  .odd_en        (odd_en),
  .pwr_n         (pwr_n),
  .odd_lane_dis  (odd_lane_dis),
  .even_lane_dis (even_lane_dis),
  .odd_ser       (odd_ser),
  .even_ser      (even_ser),
  .odd_clk_ser   (odd_clk_ser),
  .even_clk_ser  (even_clk_ser),
  .cap           (cap),
  .load          (load)
);

// File: tb/vsr_serializer_test.sv
module vsr_serializer_test;
  localparam int LANES = 5;
  localparam int NL    = 2*LANES + 2;
  localparam int PW    = LANES*7;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_clk, edge_sel, dual_mode, odd_en, even_en, pwr_n;
  logic [LANES-1:0] odd_lane_dis, even_lane_dis;
  logic [PW-1:0] odd_pix, even_pix;
  logic [LANES-1:0] odd_ser, even_ser;
  logic odd_clk_ser, even_clk_ser;

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  typedef struct packed {
    int unsigned          start;
    logic [NL-1:0][6:0]   exp;
  } frame_t;

  frame_t sbq[$];
  string  tagq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vsr_serializer #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .edge_sel(edge_sel),
    .dual_mode(dual_mode), .odd_en(odd_en), .even_en(even_en), .pwr_n(pwr_n),
    .odd_lane_dis(odd_lane_dis), .even_lane_dis(even_lane_dis),
    .odd_pix(odd_pix), .even_pix(even_pix),
    .odd_ser(odd_ser), .even_ser(even_ser),
    .odd_clk_ser(odd_clk_ser), .even_clk_ser(even_clk_ser)
  );

  // serial slot p carries parallel bit ord[p] (R1)
  function automatic logic [6:0] lane_bits(input logic [6:0] w, input logic on);
    int ord[7] = '{1, 0, 6, 5, 4, 3, 2};
    logic [6:0] r;
    for (int p = 0; p < 7; p++) r[p] = on & w[ord[p]];
    return r;
  endfunction

  // clock lane 1,1,0,0,0,1,1 (R4)
  function automatic logic [6:0] clk_bits(input logic on);
    logic [6:0] r;
    r = 7'b1100011;
    return on ? r : 7'b0;
  endfunction

  function automatic logic [PW-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return t[PW-1:0];
  endfunction

  task automatic push_frame(input string tag);
    frame_t it;
    logic on_odd, on_even;
    on_odd  = pwr_n & odd_en;
    on_even = pwr_n & even_en & dual_mode;
    it.start = cyc;
    for (int l = 0; l < LANES; l++) begin
      it.exp[l]         = lane_bits(odd_pix[l*7 +: 7],  on_odd  & ~odd_lane_dis[l]);
      it.exp[LANES+1+l] = lane_bits(even_pix[l*7 +: 7], on_even & ~even_lane_dis[l]);
    end
    it.exp[LANES]     = clk_bits(on_odd);
    it.exp[2*LANES+1] = clk_bits(on_even);
    sbq.push_back(it);
    tagq.push_back(tag);
  endtask

  // driver: back-to-back frames, seven bit clocks apart
  task automatic run_burst(input int nframes, input string tag);
    @(negedge clk);
    pix_clk = ~edge_sel;
    repeat (3) @(negedge clk);
    for (int f = 0; f < nframes; f++) begin
      odd_pix  = rnd_word();
      even_pix = rnd_word();
      pix_clk  = edge_sel;
      push_frame(tag);
      repeat (3) @(negedge clk);
      // other transition plus fresh garbage: must not reach the line (R3, R11)
      pix_clk  = ~edge_sel;
      odd_pix  = rnd_word();
      even_pix = rnd_word();
      repeat (4) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  // monitor: first slot seen two bit-clock edges after the driving negedge (R2)
  initial begin
    frame_t it;
    string tg;
    logic [NL-1:0][6:0] got;
    logic [NL-1:0] obs;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0 && cyc == sbq[0].start + 2) begin
        it = sbq.pop_front();
        tg = tagq.pop_front();
        for (int p = 0; p < 7; p++) begin
          if (p > 0) @(negedge clk);
          obs = {even_clk_ser, even_ser, odd_clk_ser, odd_ser};
          for (int l = 0; l < NL; l++) got[l][p] = obs[l];
        end
        for (int l = 0; l < NL; l++) begin
          checks++;
          if (got[l] !== it.exp[l]) begin
            errors++;
            $display("FAIL %s lane %0d: got %b expected %b", tg, l, got[l], it.exp[l]);
          end
        end
      end
    end
  end

  initial begin
    #(8*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_clk = 1'b0; edge_sel = 1'b1; dual_mode = 1'b1;
    odd_en = 1'b1; even_en = 1'b1; pwr_n = 1'b1;
    odd_lane_dis = '0; even_lane_dis = '0; odd_pix = '1; even_pix = '1;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    checks++;
    if ({even_clk_ser, even_ser, odd_clk_ser, odd_ser} !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs: got %b expected 0",
               {even_clk_ser, even_ser, odd_clk_ser, odd_ser});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_burst(4, "R1 R2 R4 R6 dual rising");
    edge_sel = 1'b0;
    run_burst(3, "R3 R11 falling edge");
    edge_sel = 1'b1;
    run_burst(2, "R3 R11 rising edge");
    dual_mode = 1'b0;
    run_burst(3, "R5 single-pixel");
    dual_mode = 1'b1; odd_en = 1'b0;
    run_burst(2, "R7 odd bank off");
    odd_en = 1'b1; even_en = 1'b0;
    run_burst(2, "R7 even bank off");
    even_en = 1'b1;
    odd_lane_dis = 5'b00101; even_lane_dis = 5'b10010;
    run_burst(3, "R8 lane disable");
    odd_lane_dis = 5'b11010; even_lane_dis = 5'b01001;
    run_burst(2, "R8 lane disable alt");
    odd_lane_dis = '0; even_lane_dis = '0;
    pwr_n = 1'b0;
    run_burst(3, "R9 power-down");
    pwr_n = 1'b1;
    edge_sel = 1'b0;
    run_burst(3, "R9 R1 resume");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule